// File: doc/BRIEF.md
# Three-level nested interrupt controller

This block gathers sixteen interrupt request lines into ten vectors and offers one vector address at a time to the processor. Each vector has one configuration bit that selects its priority level. The two lowest vectors choose between the top level and low. Every other vector chooses between high and low. A vector requests service when any of its sources is both pending and enabled. Among the vectors that request, the one with the strongest level wins. When levels are equal, the vector with the smaller address wins.

The controller records which levels are currently being served. An acknowledge from the processor marks the level of the presented vector as in service. A return marks the end of the deepest handler and releases the strongest recorded level. A new request is presented only when its level is strictly above every level in service, so a handler can only be interrupted by a more urgent one. The presented address and the request flag are registered. They hold still from the moment they are raised until the processor acknowledges them.

Top module: `irqc_top`

## Requirements
- R1: After reset `irq` is 0, `vec_addr` is 0x00 and no level is in service, so the first eligible request of any level is presented.
- R2: Sources map to vectors as follows: sources 0 and 1 go to vectors 0 and 1, sources 2–4 to vector 2, sources 5–7 to vector 3, source 8 to vector 4, sources 9–10 to vector 5, sources 11, 12 and 13 to vectors 6, 7 and 8, and sources 14–15 to vector 9. Vector n is presented at address 0x03 + 8·n.
- R3: A source whose `src_en` bit is 0 never causes a request. A vector requests when the OR of its pending and enabled sources is 1.
- R4: For vectors 0 and 1, `vec_hi` bit = 1 selects the top level and 0 selects low. For vectors 2–9, 1 selects high and 0 selects low. The levels rank top > high > low.
- R5: When several vectors are eligible at once, the one with the strongest level is presented.
- R6: When eligible vectors have equal levels, the one with the lowest address is presented.
- R7: `irq` rises on the clock edge after an eligible request is present. While `irq` is 1 and `ack` is 0, `irq` and `vec_addr` hold their values, even if the requests change.
- R8: `ack` while `irq` is 1 drops `irq` on the next edge and marks the presented level as in service. `ack` while `irq` is 0 has no effect.
- R9: While levels are in service, a request is presented only if its level is strictly above the strongest level in service.
- R10: `reti` releases only the strongest level in service. With nothing in service it has no effect.
- R11: When `ack` (with `irq` = 1) and `reti` occur in the same cycle, the release is applied first and the acknowledged level is marked afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 16 | Pending request per source |
| src_en | input | 16 | Enable per source |
| vec_hi | input | 10 | Level select per vector (see R4) |
| ack | input | 1 | Processor accepts the presented vector |
| reti | input | 1 | Processor leaves the current handler |
| irq | output | 1 | Registered interrupt request |
| vec_addr | output | 8 | Registered address of the presented vector |

## Verification
The hardest state to reach from the ports is a two-deep nest in which the order of release and marking is visible. This happens when a top-level acknowledge and a return arrive in the same cycle. The two possible orders leave different levels in service, and that difference is only visible through which later requests are still refused. The stimulus builds the nest in stages: a high vector is acknowledged, then a top vector. A request at the level that ought to remain blocked is kept pending, and `irq` is watched over the following returns. Sweeps over every source, under both level settings, and a long pseudo-random series of request, enable and level patterns cover the mapping and the arbitration.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_TOP  = 2'd3
  } lvl_e;

  localparam int LV_BITS = 2;

  // vector served by each source; sharing groups neighbouring sources
  function automatic int src_to_vec(int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2, 3, 4: return 2;
      5, 6, 7: return 3;
      8:       return 4;
      9, 10:   return 5;
      11:      return 6;
      12:      return 7;
      13:      return 8;
      14, 15:  return 9;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/irqc_gather.sv
module irqc_gather
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_VEC     = 10,
  parameter int NUM_TOP_VEC = 2
) (
  input  logic [NUM_SRC-1:0]              src_req,
  input  logic [NUM_SRC-1:0]              src_en,
  input  logic [NUM_VEC-1:0]              vec_hi,
  output logic [NUM_VEC-1:0]              vec_req,
  output logic [NUM_VEC-1:0][LV_BITS-1:0] vec_lvl
);

  function automatic logic [NUM_SRC-1:0] member_mask(int v);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      m[i] = (src_to_vec(i) == v);
    end
    return m;
  endfunction

  logic [NUM_SRC-1:0] live_src;
  assign live_src = src_req & src_en;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam logic [NUM_SRC-1:0] MEMBERS = member_mask(v);

    assign vec_req[v] = |(live_src & MEMBERS);

    if (v < NUM_TOP_VEC) begin : g_top_capable
      assign vec_lvl[v] = vec_hi[v] ? LV_TOP : LV_LOW;
    end else begin : g_plain
      assign vec_lvl[v] = vec_hi[v] ? LV_HIGH : LV_LOW;
    end
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NUM_VEC = 10,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_VEC-1:0]              vec_req,
  input  logic [NUM_VEC-1:0][LV_BITS-1:0] vec_lvl,
  input  logic [LV_BITS-1:0]              ceil,
  output logic                            win_vld,
  output logic [IDX_W-1:0]                win_idx,
  output logic [LV_BITS-1:0]              win_lvl
);

  // scan from the top index down; ">=" lets a lower index displace an equal level
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = LV_NONE;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (vec_req[v] && (vec_lvl[v] > ceil) && (vec_lvl[v] >= win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(v);
        win_lvl = vec_lvl[v];
      end
    end
  end

endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [LV_BITS-1:0] take_lvl,
  input  logic               ret,
  output logic [LV_BITS-1:0] ceil
);

  localparam int NLV = 3;

  logic [NLV-1:0] busy_q;
  logic [NLV-1:0] busy_d;
  logic [NLV-1:0] after_ret;
  logic [NLV-1:0] mark;
  logic           busy_en;

  always_comb begin
    if (busy_q[2])      ceil = LV_TOP;
    else if (busy_q[1]) ceil = LV_HIGH;
    else if (busy_q[0]) ceil = LV_LOW;
    else                ceil = LV_NONE;
  end

  always_comb begin
    after_ret = busy_q;
    if (ret) begin
      if (busy_q[2])      after_ret[2] = 1'b0;
      else if (busy_q[1]) after_ret[1] = 1'b0;
      else                after_ret[0] = 1'b0;
    end
  end

  always_comb begin
    mark = '0;
    if (take) begin
      case (take_lvl)
        LV_LOW:  mark = 3'b001;
        LV_HIGH: mark = 3'b010;
        LV_TOP:  mark = 3'b100;
        default: mark = 3'b000;
      endcase
    end
  end

  assign busy_en = take | ret;
  assign busy_d  = after_ret | mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_VEC     = 10,
  parameter int NUM_TOP_VEC = 2,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_VEC-1:0] vec_hi,
  input  logic               ack,
  input  logic               reti,
  output logic               irq,
  output logic [ADDR_W-1:0]  vec_addr
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0]              vec_req;
  logic [NUM_VEC-1:0][LV_BITS-1:0] vec_lvl;
  logic [LV_BITS-1:0]              ceil;
  logic                            win_vld;
  logic [IDX_W-1:0]                win_idx;
  logic [LV_BITS-1:0]              win_lvl;

  logic                            irq_q, irq_d;
  logic [ADDR_W-1:0]               addr_q, addr_d;
  logic [LV_BITS-1:0]              lvl_q;
  logic                            load, take;

  irqc_gather #(
    .NUM_SRC    (NUM_SRC),
    .NUM_VEC    (NUM_VEC),
    .NUM_TOP_VEC(NUM_TOP_VEC)
  ) u_gather (
    .src_req(src_req),
    .src_en (src_en),
    .vec_hi (vec_hi),
    .vec_req(vec_req),
    .vec_lvl(vec_lvl)
  );

  irqc_arbiter #(
    .NUM_VEC(NUM_VEC),
    .IDX_W  (IDX_W)
  ) u_arb (
    .vec_req(vec_req),
    .vec_lvl(vec_lvl),
    .ceil   (ceil),
    .win_vld(win_vld),
    .win_idx(win_idx),
    .win_lvl(win_lvl)
  );

  irqc_svc_stack u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_lvl(lvl_q),
    .ret     (reti),
    .ceil    (ceil)
  );

  // next state of the presentation register
  always_comb begin
    take   = irq_q & ack;
    load   = ~irq_q & win_vld;
    irq_d  = load | (irq_q & ~ack);
    addr_d = ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lvl_q  <= LV_NONE;
    end else if (load) begin
      addr_q <= addr_d;
      lvl_q  <= win_lvl;
    end
  end

  assign irq      = irq_q;
  assign vec_addr = addr_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_VEC  = 10,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_req,
  input logic [NUM_SRC-1:0] src_en,
  input logic               ack,
  input logic               reti,
  input logic               irq,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic [1:0]         ceil,
  input logic [1:0]         lvl_q
);

  localparam int ADDR_MAX = VEC_BASE + VEC_STEP * (NUM_VEC - 1);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq && $stable(vec_addr));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ack |=> !irq);

  assert_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ack && !reti |=> ceil == $past(lvl_q));

  assert_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int'(vec_addr) >= VEC_BASE) && (int'(vec_addr) <= ADDR_MAX)
            && (((int'(vec_addr) - VEC_BASE) % VEC_STEP) == 0));

  assert_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(src_req & src_en)));

  assert_nest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> lvl_q > $past(ceil));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !ack && (ceil != 2'd0) |=> ceil < $past(ceil));

endmodule

bind irqc_top irqc_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_VEC (NUM_VEC),
  .ADDR_W  (ADDR_W),
  .VEC_BASE(VEC_BASE),
  .VEC_STEP(VEC_STEP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_req (src_req),
  .src_en  (src_en),
  .ack     (ack),
  .reti    (reti),
  .irq     (irq),
  .vec_addr(vec_addr),
  .ceil    (ceil),
  .lvl_q   (lvl_q)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] src_req;
  logic [15:0] src_en;
  logic [9:0]  vec_hi;
  logic        ack;
  logic        reti;
  logic        irq;
  logic [7:0]  vec_addr;

  int n_chk;
  int n_err;
  bit done;

  irqc_top u_irqc_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .src_en  (src_en),
    .vec_hi  (vec_hi),
    .ack     (ack),
    .reti    (reti),
    .irq     (irq),
    .vec_addr(vec_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int vec_of(int s);
    if (s < 2)   return s;
    if (s < 5)   return 2;
    if (s < 8)   return 3;
    if (s == 8)  return 4;
    if (s < 11)  return 5;
    if (s < 14)  return s - 5;
    return 9;
  endfunction

  function automatic int addr_of(int v);
    return 3 + 8 * v;
  endfunction

  function automatic int model_win(logic [15:0] rq, logic [15:0] en, logic [9:0] hi, int ceil);
    int best;
    int idx;
    best = 0;
    idx  = -1;
    for (int v = 0; v < 10; v++) begin
      bit any;
      int lv;
      any = 1'b0;
      for (int s = 0; s < 16; s++) begin
        if (vec_of(s) == v && rq[s] && en[s]) any = 1'b1;
      end
      if (any) begin
        lv = hi[v] ? ((v < 2) ? 3 : 2) : 1;
        if (lv > ceil && lv > best) begin
          best = lv;
          idx  = v;
        end
      end
    end
    return idx;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    tick();
    reti = 1'b0;
  endtask

  task automatic drain();
    src_req = '0;
    do_reti();
    do_reti();
    do_reti();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    n_chk   = 0;
    n_err   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    src_req = '0;
    src_en  = '0;
    vec_hi  = '0;
    ack     = 1'b0;
    reti    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 addr after reset", 32'(vec_addr), 32'h00);

    // R8: ack without a presented request is ignored; R10: reti with nothing in service
    do_ack();
    do_reti();
    src_en  = '1;
    src_req = 16'h1000;
    tick();
    chk("R1 R8 R10 low request presented", 32'(irq), 32'd1);
    chk("R1 low request addr", 32'(vec_addr), 32'h3B);
    do_ack();
    drain();

    // R2 R4 R8 sweep over every source and both level settings
    for (int s = 0; s < 16; s++) begin
      for (int h = 0; h < 2; h++) begin
        int v;
        int p;
        int ps;
        v = vec_of(s);
        p = (v == 4) ? 9 : 4;
        ps = (p == 4) ? 8 : 14;
        src_en  = '1;
        vec_hi  = (h != 0) ? 10'h3FF : 10'h000;
        src_req = 16'(1) << s;
        tick();
        chk("R2 source raises", 32'(irq), 32'd1);
        chk("R2 vector addr", 32'(vec_addr), 32'(addr_of(v)));
        do_ack();
        chk("R8 irq drops on ack", 32'(irq), 32'd0);
        vec_hi[p] = 1'b1;
        src_req   = 16'(1) << ps;
        tick();
        chk("R4 served level vs high probe", 32'(irq), (h != 0) ? 32'd0 : 32'd1);
        if (irq) do_ack();
        drain();
      end
    end

    // R3 disabled sources ignored
    for (int s = 0; s < 16; s++) begin
      src_en  = ~(16'(1) << s);
      vec_hi  = '1;
      src_req = 16'(1) << s;
      tick();
      tick();
      chk("R3 disabled source", 32'(irq), 32'd0);
      drain();
    end

    // R5 R6 R3 pseudo-random patterns, nothing in service
    lfsr = 32'h1ACE_B00C;
    for (int it = 0; it < 400; it++) begin
      int w;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      src_req = lfsr[15:0];
      src_en  = lfsr[31:16] | lfsr[23:8];
      vec_hi  = lfsr[9:0] ^ lfsr[29:20];
      w = model_win(src_req, src_en, vec_hi, 0);
      tick();
      chk("R5 R6 R3 irq", 32'(irq), (w >= 0) ? 32'd1 : 32'd0);
      if (w >= 0) begin
        chk("R5 R6 winner addr", 32'(vec_addr), 32'(addr_of(w)));
        do_ack();
      end
      drain();
    end

    // R9 R10 nesting
    src_en  = '1;
    vec_hi  = 10'b00_0010_0101;
    src_req = 16'h0004;
    tick();
    chk("R9 high vector presented", 32'(vec_addr), 32'h13);
    do_ack();
    src_req = 16'h1200;
    tick();
    chk("R9 same and lower blocked", 32'(irq), 32'd0);
    tick();
    chk("R9 still blocked", 32'(irq), 32'd0);
    src_req = 16'h1201;
    tick();
    chk("R9 strictly higher accepted", 32'(irq), 32'd1);
    chk("R9 top addr", 32'(vec_addr), 32'h03);
    do_ack();
    tick();
    chk("R9 top blocks top", 32'(irq), 32'd0);
    src_req = 16'h1200;
    do_reti();
    tick();
    chk("R10 only top released", 32'(irq), 32'd0);
    do_reti();
    tick();
    chk("R10 high released", 32'(irq), 32'd1);
    chk("R10 high vector addr", 32'(vec_addr), 32'h2B);
    do_ack();
    src_req = 16'h1000;
    tick();
    chk("R9 low blocked under high", 32'(irq), 32'd0);
    do_reti();
    tick();
    chk("R10 low after release", 32'(vec_addr), 32'h3B);
    chk("R10 low presented", 32'(irq), 32'd1);
    do_ack();
    drain();

    // R7 presentation holds until ack
    vec_hi  = '0;
    src_req = 16'h4000;
    tick();
    chk("R7 low vector addr", 32'(vec_addr), 32'h4B);
    vec_hi[0] = 1'b1;
    src_req   = 16'h4001;
    tick();
    chk("R7 hold irq", 32'(irq), 32'd1);
    chk("R7 hold addr", 32'(vec_addr), 32'h4B);
    src_req = 16'h0001;
    tick();
    chk("R7 hold after source drop", 32'(vec_addr), 32'h4B);
    do_ack();
    chk("R8 drop", 32'(irq), 32'd0);
    tick();
    chk("R7 new winner after ack", 32'(vec_addr), 32'h03);
    chk("R7 new irq after ack", 32'(irq), 32'd1);
    do_ack();
    drain();

    // R11 ack and reti together: release first, then mark
    vec_hi  = 10'b00_0010_0101;
    src_req = 16'h0004;
    tick();
    do_ack();
    src_req = 16'h0001;
    tick();
    chk("R11 top presented", 32'(vec_addr), 32'h03);
    ack  = 1'b1;
    reti = 1'b1;
    tick();
    ack  = 1'b0;
    reti = 1'b0;
    tick();
    chk("R11 top remains in service", 32'(irq), 32'd0);
    tick();
    chk("R11 top still blocked", 32'(irq), 32'd0);
    do_reti();
    tick();
    chk("R11 top accepted after release", 32'(irq), 32'd1);
    chk("R11 top addr", 32'(vec_addr), 32'h03);
    do_ack();
    drain();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule